// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block generates the row-strobe and column-strobe timing for a group of DRAM banks. Each bank has its own enable for page mode. A bank with page mode enabled keeps its row open after an access. For every bank the block records the address of the last access and whether that bank's row strobe is still held. When a new request arrives, the block compares the request with that state and picks one of four sequences:

- a column-only cycle (page hit),
- a precharge followed by a full cycle (page miss),
- a full cycle that first closes the other bank's row (bank switch),
- a closed-row full cycle for banks without page mode.

A requester presents an address, a bank number and a read/write flag while `req_ready` is high. It then waits for the one-cycle `done` pulse. The pulse comes with a code that reports which sequence ran. Each bank has its own settings: page size, precharge length, and an extra write wait state on hits. Each bank also has a flag for overlapping address ranges, and this flag forces page mode off for that bank.

Top module: `dram_page_seq`

## Requirements
- R1: After reset all `ras_n` bits and `cas_n` are 1 and `req_ready` is 1. The first access to any bank never classifies as a hit or miss.
- R2: A page hit (same bank still open, same page) takes latency 1, where latency counts rising edges from the accepting edge to the edge that raises `done`. No row phase runs, `ras_n` does not change, and `done_kind` is 0.
- R3: A write hit on a bank whose `cfg_wr_wait` bit is set takes one extra cycle (latency 2).
- R4: The write wait state applies only to write hits. Read hits, and writes of any other kind, have no extra cycle.
- R5: A page miss (same bank still open, different page) reports `done_kind` 1. It holds all `ras_n` high for max(1, precharge count) cycles, then runs row and column phases. Latency is max(1,P)+2.
- R6: Two addresses are on the same page when they agree in every bit at or above position `COL_MIN + cfg_page_sel[bank]`.
- R7: An access to a page-mode bank that is not the currently open bank is a bank switch (`done_kind` 2) with latency 2. The other bank's row strobe is negated and the target's is asserted.
- R8: A bank with page mode disabled, or with its overlap flag set, always runs a plain cycle (`done_kind` 3) with latency 2. All `ras_n` are 1 when `done` is high.
- R9: After a hit, miss or switch, the target bank's `ras_n` remains 0 until an access to a different bank.
- R10: At most one `ras_n` bit is 0 at any time, and `cas_n` is 0 only while some `ras_n` is 0.
- R11: `done` is a single-cycle pulse, and `req_ready` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted on this edge if valid |
| req_addr | input | ADDR_W | Request address |
| req_bank | input | BANK_W | Target bank number |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_page_en | input | NUM_BANKS | Per-bank page mode enable |
| cfg_overlap | input | NUM_BANKS | Per-bank overlapping-range flag, disables page mode |
| cfg_page_sel | input | NUM_BANKS*SEL_W | Per-bank page size select |
| cfg_wr_wait | input | NUM_BANKS | Per-bank extra wait on write hits |
| cfg_prech | input | NUM_BANKS*PRE_W | Per-bank precharge clocks (0 acts as 1) |
| ras_n | output | NUM_BANKS | Row strobes, active low |
| cas_n | output | 1 | Column strobe, active low |
| done | output | 1 | Access complete pulse |
| done_kind | output | 2 | Sequence used: 0 hit, 1 miss, 2 switch, 3 plain |

## Verification
Every cycle, the assertions check strobe exclusivity, that the column strobe only runs under an open row, that `done` is a single pulse and that `ready` is low while it is high. They also check that hits leave the row strobes unchanged, that plain cycles end with every row closed, and that other cycles end with exactly one row open. Only the bench scenarios can show that a hit, miss, switch or plain cycle was chosen for a given history. The same applies to the exact latency of each sequence, including the zero-count precharge and the write wait. The page-size compare and the row left open after each access also depend on the scenarios.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    K_HIT    = 2'd0,
    K_MISS   = 2'd1,
    K_SWITCH = 2'd2,
    K_PLAIN  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/dps_page_track.sv
module dps_page_track
  import dps_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int COL_MIN   = 8,
  parameter int SEL_W     = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fire,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic [NUM_BANKS-1:0]       cfg_page_en,
  input  logic [NUM_BANKS-1:0]       cfg_overlap,
  input  logic [NUM_BANKS*SEL_W-1:0] cfg_page_sel,
  output acc_kind_e                  kind
);
  logic [ADDR_W-1:0]    last_addr [NUM_BANKS];
  logic [NUM_BANKS-1:0] last_vld;
  logic                 open_vld;
  logic [BANK_W-1:0]    open_bank;
  logic [NUM_BANKS-1:0] pm_eff;

  assign pm_eff = cfg_page_en & ~cfg_overlap;

  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] diff;
  logic              same_page;
  logic              same_open;

  always_comb begin
    sel       = cfg_page_sel[req_bank*SEL_W +: SEL_W];
    diff      = (req_addr ^ last_addr[req_bank]) >> (COL_MIN + int'(sel));
    same_page = (diff == '0);
    same_open = open_vld && (open_bank == req_bank) && last_vld[req_bank];
    if (!pm_eff[req_bank])  kind = K_PLAIN;
    else if (!same_open)    kind = K_SWITCH;
    else if (same_page)     kind = K_HIT;
    else                    kind = K_MISS;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          last_vld[g]  <= 1'b0;
          last_addr[g] <= '0;
        end else if (fire && req_bank == BANK_W'(g) && pm_eff[g]) begin
          last_vld[g]  <= 1'b1;
          last_addr[g] <= req_addr;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld  <= 1'b0;
      open_bank <= '0;
    end else if (fire) begin
      open_vld  <= pm_eff[req_bank];
      open_bank <= req_bank;
    end
  end
endmodule

// File: rtl/dps_prech_cnt.sv
module dps_prech_cnt #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  output logic             last
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= (load_val == '0) ? PRE_W'(1) : load_val;
    else if (cnt != '0)   cnt <= cnt - PRE_W'(1);
  end

  assign last = (cnt == PRE_W'(1));
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dps_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int COL_MIN   = 8,
  parameter int SEL_W     = 2,
  parameter int PRE_W     = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic                       req_write,
  input  logic [NUM_BANKS-1:0]       cfg_page_en,
  input  logic [NUM_BANKS-1:0]       cfg_overlap,
  input  logic [NUM_BANKS*SEL_W-1:0] cfg_page_sel,
  input  logic [NUM_BANKS-1:0]       cfg_wr_wait,
  input  logic [NUM_BANKS*PRE_W-1:0] cfg_prech,
  output logic [NUM_BANKS-1:0]       ras_n,
  output logic                       cas_n,
  output logic                       done,
  output logic [1:0]                 done_kind
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ROW, S_COL, S_WAIT, S_END} state_e;

  state_e            state;
  acc_kind_e         kind, cur_kind;
  logic [BANK_W-1:0] cur_bank;
  logic              need_wait;
  logic              fire;
  logic              pre_last;

  assign req_ready = (state == S_IDLE);
  assign fire      = req_valid && req_ready;

  dps_page_track #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .COL_MIN(COL_MIN), .SEL_W(SEL_W)
  ) u_track (
    .clk(clk), .rst(rst), .fire(fire), .req_addr(req_addr), .req_bank(req_bank),
    .cfg_page_en(cfg_page_en), .cfg_overlap(cfg_overlap),
    .cfg_page_sel(cfg_page_sel), .kind(kind)
  );

  dps_prech_cnt #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst),
    .load(fire && kind == K_MISS),
    .load_val(cfg_prech[req_bank*PRE_W +: PRE_W]),
    .last(pre_last)
  );

  function automatic logic [NUM_BANKS-1:0] row_open(input logic [BANK_W-1:0] b);
    logic [NUM_BANKS-1:0] v;
    v = '1;
    v[b] = 1'b0;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ras_n     <= '1;
      cas_n     <= 1'b1;
      done      <= 1'b0;
      done_kind <= 2'd0;
      cur_kind  <= K_HIT;
      cur_bank  <= '0;
      need_wait <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (fire) begin
          cur_kind  <= kind;
          cur_bank  <= req_bank;
          need_wait <= (kind == K_HIT) && req_write && cfg_wr_wait[req_bank];
          case (kind)
            K_HIT: begin
              state <= S_COL;
              cas_n <= 1'b0;
            end
            K_MISS: begin
              state <= S_PRE;
              ras_n <= '1;
            end
            default: begin
              state <= S_ROW;
              ras_n <= row_open(req_bank);
            end
          endcase
        end
        S_PRE: if (pre_last) begin
          state <= S_ROW;
          ras_n <= row_open(cur_bank);
        end
        S_ROW: begin
          state <= S_COL;
          cas_n <= 1'b0;
        end
        S_COL: begin
          if (need_wait) begin
            state <= S_WAIT;
          end else begin
            state     <= S_END;
            cas_n     <= 1'b1;
            done      <= 1'b1;
            done_kind <= cur_kind;
            if (cur_kind == K_PLAIN) ras_n <= '1;
          end
        end
        S_WAIT: begin
          state     <= S_END;
          cas_n     <= 1'b1;
          done      <= 1'b1;
          done_kind <= cur_kind;
        end
        S_END: begin
          state <= S_IDLE;
          done  <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BANKS-1:0] ras_n,
  input logic                 cas_n,
  input logic                 done,
  input logic [1:0]           done_kind,
  input logic                 req_ready
);
  AST_RESET_CLOSED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&ras_n && cas_n && req_ready)); // R1

  AST_HIT_NO_ROW: assert property (@(posedge clk) disable iff (rst)
    (done && done_kind == 2'd0) |-> $stable(ras_n)); // R2

  AST_PLAIN_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (done && done_kind == 2'd3) |-> &ras_n); // R8

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (done && done_kind != 2'd3) |-> ($countones(~ras_n) == 1)); // R9

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n)); // R10

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !(&ras_n)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready); // R11
endmodule

bind dram_page_seq dps_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n),
  .done(done), .done_kind(done_kind), .req_ready(req_ready)
);

// File: tb/dram_page_seq_bench.sv
module dram_page_seq_bench;
  localparam int NB = 4, AW = 16, CM = 8, SW = 2, PW = 3, BW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_bank = '0;
  logic req_write = 1'b0;
  logic [NB-1:0] cfg_page_en, cfg_overlap, cfg_wr_wait;
  logic [NB*SW-1:0] cfg_page_sel;
  logic [NB*PW-1:0] cfg_prech;
  logic [NB-1:0] ras_n;
  logic cas_n, done;
  logic [1:0] done_kind;

  always #2 clk = ~clk;

  dram_page_seq #(.NUM_BANKS(NB), .ADDR_W(AW), .COL_MIN(CM), .SEL_W(SW), .PRE_W(PW))
  u_dram_page_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bank(req_bank), .req_write(req_write),
    .cfg_page_en(cfg_page_en), .cfg_overlap(cfg_overlap),
    .cfg_page_sel(cfg_page_sel), .cfg_wr_wait(cfg_wr_wait),
    .cfg_prech(cfg_prech), .ras_n(ras_n), .cas_n(cas_n),
    .done(done), .done_kind(done_kind)
  );

  typedef struct {
    logic [1:0]    kind;
    int            lat;
    logic [NB-1:0] ras;
    int            acc;
    string         req;
  } exp_t;

  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0, cyc = 0, n_done = 0;

  // reference model state
  logic [AW-1:0] m_last [NB];
  logic [NB-1:0] m_vld = '0;
  bit m_open = 0;
  int m_open_bank = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      n_done++;
      if (sbq.size() == 0) begin
        check(0, "R11", "unexpected done", 1, 0);
      end else begin
        e = sbq.pop_front();
        check(done_kind == e.kind, e.req, "kind", done_kind, e.kind);
        check((cyc - e.acc) == e.lat, e.req, "latency", cyc - e.acc, e.lat);
        check(ras_n == e.ras, e.req, "ras_n at done", ras_n, e.ras);
        check(!req_ready, "R11", "ready during done", req_ready, 0);
      end
    end
  end

  task automatic access(input int bank, input logic [AW-1:0] addr, input bit wr, input string req);
    exp_t e;
    bit pm, same;
    int sh, p;
    pm = cfg_page_en[bank] && !cfg_overlap[bank];
    sh = CM + int'(cfg_page_sel[bank*SW +: SW]);
    same = ((addr ^ m_last[bank]) >> sh) == 0;
    p = int'(cfg_prech[bank*PW +: PW]);
    if (p == 0) p = 1;
    if (!pm) begin
      e.kind = 2'd3; e.lat = 2; e.ras = '1;
    end else if (!(m_open && m_open_bank == bank && m_vld[bank])) begin
      e.kind = 2'd2; e.lat = 2;
    end else if (same) begin
      e.kind = 2'd0; e.lat = (wr && cfg_wr_wait[bank]) ? 2 : 1;
    end else begin
      e.kind = 2'd1; e.lat = p + 2;
    end
    if (pm) begin
      e.ras = '1; e.ras[bank] = 1'b0;
      m_last[bank] = addr; m_vld[bank] = 1'b1;
      m_open = 1; m_open_bank = bank;
    end else begin
      m_open = 0;
    end
    e.req = req;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_bank = BW'(bank); req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e.acc = cyc;
    sbq.push_back(e);
  endtask

  initial begin
    cfg_page_en  = 4'b1011;
    cfg_overlap  = 4'b1000;
    cfg_wr_wait  = 4'b0001;
    cfg_page_sel = {2'd0, 2'd0, 2'd2, 2'd0};
    cfg_prech    = {3'd0, 3'd0, 3'd0, 3'd2};
    for (int i = 0; i < NB; i++) m_last[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ras_n == '1, "R1", "ras_n after reset", ras_n, 4'hF);
    check(cas_n == 1'b1, "R1", "cas_n after reset", cas_n, 1);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    access(0, 16'h1234, 0, "R1");   // first access: switch
    access(0, 16'h12FF, 0, "R2");   // read hit
    access(0, 16'h1200, 1, "R3");   // write hit with wait
    access(0, 16'h3400, 1, "R5");   // write miss, precharge 2, no wait (R4)
    access(1, 16'h0100, 0, "R7");   // bank switch
    access(1, 16'h0300, 1, "R6");   // same page under 1 KiB pages, write hit no wait (R4)
    access(1, 16'h0400, 0, "R5");   // miss, precharge count 0 -> 1
    access(2, 16'h0400, 0, "R8");   // page mode disabled
    access(1, 16'h0400, 0, "R9");   // row closed by plain access -> switch
    access(3, 16'h0000, 1, "R8");   // overlap forces plain
    access(0, 16'h3400, 0, "R7");   // back to bank 0: switch
    access(0, 16'h3401, 0, "R9");   // row still open: hit
    access(0, 16'h34FF, 1, "R4");   // write hit, wait applies
    repeat (8) @(negedge clk);
    check(ras_n == 4'b1110, "R9", "row held after idle", ras_n, 4'b1110);
    check(sbq.size() == 0, "R11", "outstanding items", sbq.size(), 0);
    check(n_done == 13, "R11", "done count", n_done, 13);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule